// File: doc/BRIEF.md
# Unsigned Array Multiplier with Mux-Gated Adder Rows

This block multiplies two N-bit unsigned operands and returns the 2N-bit product. It is a chain of N adder rows. Row i handles multiplier bit i. It adds the multiplicand to the running partial sum at a left shift of i bits.

No row gates the multiplicand with its multiplier bit before the adder. The adder always forms the full sum of the multiplicand and the incoming partial sum. A 2:1 multiplexer then picks one result for every bit of the row's window. When the row's multiplier bit is set, the mux takes the fresh sum. When the bit is clear, it takes the incoming partial sum unchanged. The row's carry-out counts as one extra sum bit and goes through the same mux, so a raw carry never reaches the next row on its own.

In the default registered form, a strobe loads a new operand pair. One clock later a valid flag rises together with the product. The product then stays fixed until the next strobe. With the parameter set for combinational use, the product follows the operands directly.

Top module: `gated_array_mult`

## Requirements
- R1: With the registered form (default, N=8), the product output equals xIn*yIn as an unsigned 2N-bit value, for the operands presented with validIn at the previous clock edge.
- R2: Row i adds the multiplicand at bit offset i unconditionally. When multiplier bit i is 1, its N+1-bit window (the carry bit included) passes the sum. When bit i is 0, the window passes the incoming partial sum. Bits outside the window pass through unchanged. This is observed as R1 holding for every operand pair.
- R3: A multiplicand of zero gives a product of zero.
- R4: A multiplier of zero gives a product of zero.
- R5: validOut is 1 in the cycle after each edge at which validIn was 1. It is 0 after an edge at which validIn was 0.
- R6: While validIn is 0, changes on xIn and yIn have no effect: the product holds its last value.
- R7: A synchronous active-high reset clears the product to 0 and validOut to 0.
- R8: All-ones operands give (2^N-1)^2, which is 16'hFE01 for N=8.
- R9: A multiplier of 1 gives the multiplicand, zero-extended.
- R10: Strobes on consecutive cycles each give their own correct product one cycle later, with validOut held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| validIn | input | 1 | Load strobe for a new operand pair |
| xIn | input | N | Multiplicand, unsigned |
| yIn | input | N | Multiplier, unsigned |
| validOut | output | 1 | Product valid, one cycle after the strobe |
| product | output | 2N | Unsigned product |

## Verification
The assertions check on every cycle the parts of the behaviour that can be stated locally:
- the one-cycle valid latency, in both directions;
- that the product holds whenever no strobe arrived;
- that a zero operand gives zero and a unit multiplier gives the multiplicand;
- the reset result.

The correctness of the mux rows as a whole, in particular that a carry is kept or dropped together with its row, only shows in the bench. The bench sweeps every operand pair for N=8, runs back-to-back strobes and walks a table of corner values.

// File: rtl/gated_mult_pkg.sv
package gated_mult_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;
  } mult_ctrl_t;
endpackage

// File: rtl/gated_mult_row.sv
// One gated adder row: the adder is never gated on its inputs; a per-bit
// 2:1 mux after it chooses the fresh sum or the incoming partial sum.
module gated_mult_row #(
  parameter int N   = 8,
  parameter int POS = 0,
  localparam int W  = 2 * N
) (
  input  logic [W-1:0] partIn,
  input  logic [N-1:0] xOp,
  input  logic         sel,
  output logic [W-1:0] partOut
);
  logic [N:0] rawSum;  // unconditional sum, carry included as top bit

  assign rawSum = {1'b0, partIn[POS +: N]} + {1'b0, xOp};

  always_comb begin
    partOut = partIn;  // bits outside the window pass through
    // carry bit is muxed like any sum bit: never forwarded raw (R2)
    partOut[POS +: N+1] = sel ? rawSum : partIn[POS +: N+1];
  end
endmodule

// File: rtl/gated_mult_ctrl.sv
module gated_mult_ctrl
  import gated_mult_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       validIn,
  output mult_ctrl_t strobes,
  output logic       validOut
);
  assign strobes.capture = validIn;

  generate
    if (REGISTERED) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (rst) validQ <= 1'b0;
        else     validQ <= validIn;
      end
      assign validOut = validQ;

      p_valid_rise_r5: assert property (@(posedge clk) disable iff (rst)
        validIn |=> validOut)
        else $error("validOut missing after strobe");
      p_valid_drop_r5: assert property (@(posedge clk) disable iff (rst)
        !validIn |=> !validOut)
        else $error("validOut without strobe");
      p_reset_valid_r7: assert property (@(posedge clk)
        rst |=> !validOut)
        else $error("validOut set after reset");
    end else begin : g_comb
      assign validOut = validIn;
    end
  endgenerate
endmodule

// File: rtl/gated_mult_datapath.sv
module gated_mult_datapath
  import gated_mult_pkg::*;
#(
  parameter int N            = 8,
  parameter bit REGISTERED   = 1'b1,
  localparam int W           = 2 * N
) (
  input  logic         clk,
  input  logic         rst,
  input  mult_ctrl_t   strobes,
  input  logic [N-1:0] xIn,
  input  logic [N-1:0] yIn,
  output logic [W-1:0] product
);
  logic [W-1:0] chain [0:N];

  assign chain[0] = '0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_row
      gated_mult_row #(.N(N), .POS(i)) u_row (
        .partIn (chain[i]),
        .xOp    (xIn),
        .sel    (yIn[i]),
        .partOut(chain[i+1])
      );
    end

    if (REGISTERED) begin : g_reg
      logic [W-1:0] prodQ;
      always_ff @(posedge clk) begin
        if (rst)                  prodQ <= '0;
        else if (strobes.capture) prodQ <= chain[N];
      end
      assign product = prodQ;

      p_zero_x_r3: assert property (@(posedge clk) disable iff (rst)
        (strobes.capture && xIn == '0) |=> product == '0)
        else $error("zero multiplicand gave nonzero product");
      p_zero_y_r4: assert property (@(posedge clk) disable iff (rst)
        (strobes.capture && yIn == '0) |=> product == '0)
        else $error("zero multiplier gave nonzero product");
      p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !strobes.capture |=> $stable(product))
        else $error("product changed without strobe");
      p_unit_y_r9: assert property (@(posedge clk) disable iff (rst)
        (strobes.capture && yIn == N'(1)) |=> product == W'($past(xIn)))
        else $error("unit multiplier mismatch");
      p_reset_prod_r7: assert property (@(posedge clk)
        rst |=> product == '0)
        else $error("product not cleared by reset");
    end else begin : g_comb
      assign product = chain[N];
    end
  endgenerate
endmodule

// File: rtl/gated_array_mult.sv
module gated_array_mult
  import gated_mult_pkg::*;
#(
  parameter int N          = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           validIn,
  input  logic [N-1:0]   xIn,
  input  logic [N-1:0]   yIn,
  output logic           validOut,
  output logic [2*N-1:0] product
);
  mult_ctrl_t strobes;

  gated_mult_ctrl #(.REGISTERED(REGISTERED)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .validIn (validIn),
    .strobes (strobes),
    .validOut(validOut)
  );

  gated_mult_datapath #(.N(N), .REGISTERED(REGISTERED)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .xIn    (xIn),
    .yIn    (yIn),
    .product(product)
  );
endmodule

// File: tb/gated_array_mult_tb.sv
`timescale 1ns/1ps
module gated_array_mult_tb;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         validIn = 1'b0;
  logic [N-1:0] xIn = '0;
  logic [N-1:0] yIn = '0;
  logic         validOut;
  logic [W-1:0] product;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gated_array_mult #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .validIn(validIn),
    .xIn(xIn), .yIn(yIn), .validOut(validOut), .product(product)
  );

  // {x, y, expected product}
  localparam logic [31:0] VEC [0:9] = '{
    {8'd0,   8'd0,   16'd0},      // R3 R4
    {8'd255, 8'd255, 16'hFE01},   // R8
    {8'd1,   8'd255, 16'd255},
    {8'd255, 8'd1,   16'd255},    // R9
    {8'd0,   8'd200, 16'd0},      // R3
    {8'd200, 8'd0,   16'd0},      // R4
    {8'd16,  8'd16,  16'd256},
    {8'd170, 8'd85,  16'd14450},
    {8'd128, 8'd128, 16'd16384},
    {8'd3,   8'd5,   16'd15}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [N-1:0] x, input logic [N-1:0] y);
    @(negedge clk);
    xIn = x; yIn = y; validIn = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Reset state (R7)
    repeat (3) @(negedge clk);
    chk("R7 product at reset", product, '0);
    chk("R7 validOut at reset", W'(validOut), '0);
    rst = 1'b0;

    // Table walk (R1 R3 R4 R8 R9)
    foreach (VEC[k]) begin
      strobe(VEC[k][31:24], VEC[k][23:16]);
      @(negedge clk);
      validIn = 1'b0;
      chk("R1 table product", product, VEC[k][15:0]);
      chk("R5 validOut after strobe", W'(validOut), W'(1));
    end

    // Hold and ignore (R6), valid drop (R5)
    strobe(8'd37, 8'd11);
    @(negedge clk);
    validIn = 1'b0;
    chk("R1 product 37*11", product, W'(407));
    xIn = 8'd200; yIn = 8'd250;
    @(negedge clk);
    chk("R5 validOut low without strobe", W'(validOut), '0);
    @(negedge clk);
    chk("R6 product held while idle", product, W'(407));

    // Exhaustive back-to-back sweep (R1 R2 R10)
    begin
      logic [W-1:0] expP = '0;
      for (int k = 0; k <= (1 << W); k++) begin
        @(negedge clk);
        if (k > 0) begin
          chk("R2 sweep product", product, expP);
          chk("R10 validOut back-to-back", W'(validOut), W'(1));
        end
        if (k < (1 << W)) begin
          xIn = k[W-1:N]; yIn = k[N-1:0]; validIn = 1'b1;
          expP = W'(k[W-1:N]) * W'(k[N-1:0]);
        end else begin
          validIn = 1'b0;
        end
      end
    end

    // Mid-run reset (R7)
    strobe(8'd99, 8'd77);
    @(negedge clk);
    validIn = 1'b0;
    chk("R1 product 99*77", product, W'(7623));
    rst = 1'b1;
    @(negedge clk);
    chk("R7 product cleared", product, '0);
    chk("R7 validOut cleared", W'(validOut), '0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule